// File: doc/BRIEF.md
# DC-Blocking Shift-Coefficient High-Pass Filter

This block strips the DC component from a stream of signed audio samples with a first-order recursive high-pass section. Each accepted sample updates two pieces of state, the previous input and the previous output. The output is the new input minus the previous input, plus a leaked copy of the previous output. The leak factor is one minus two to the power of minus k, so it needs only an arithmetic shift and a subtract, and no multiplier.

The shift amount k is a static 4-bit input. Zero selects a pass-through path. Values from 1 to 12 select a filter corner, and larger values are treated as 12. The previous output is held with extra fraction bits, so small corners do not lose precision. The output is rounded and clamped back to the sample width. A synchronous clear input and any change of k both return the state to rest. The block then treats the next sample as the first one after silence.

Top module: `hpf_dc_block`

## Requirements
- R1: For k in 1..12, each accepted sample x computes acc = acc − (acc >>> k) + ((x − xPrev) << 12), where acc is a 32-bit signed value with 12 fraction bits and >>> is an arithmetic shift. The output is (acc + 2048) >>> 12, which rounds half up.
- R2: When k = 0 the output equals the input sample, with the same one-cycle latency, and the internal state stays at zero.
- R3: Values of k from 13 to 15 give exactly the same outputs as k = 12.
- R4: outValid is high in the cycle after a cycle with inValid high, and low in every other cycle.
- R5: In a cycle with inValid low, neither the state nor outSample changes, whatever value inSample carries.
- R6: clearIn high in a cycle sets xPrev and acc to zero. If inValid is also high in that cycle, the sample is filtered from zero state.
- R7: A cycle in which shiftK differs from its value in the previous cycle behaves like clearIn for the state. A sample arriving in that same cycle is filtered with the new k from zero state.
- R8: The rounded output is clamped to the range −32768..32767.
- R9: From rest, the first output after a step to a value S equals S.
- R10: With a constant input held long enough, the output decays to a magnitude of at most 1.
- R11: After reset, outValid is 0, outSample is 0, and the state is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearIn | input | 1 | Synchronous state clear |
| shiftK | input | 4 | Leak shift amount; 0 selects bypass |
| inValid | input | 1 | Input sample strobe |
| inSample | input | 16 | Signed input sample |
| outValid | output | 1 | Output sample strobe |
| outSample | output | 16 | Signed filtered sample |

## Verification
Every one of the sixteen k codes is driven with the same patterns, and every output is compared with a bench model of the recurrence:
- A held step separates the exact first-sample value from the shift-and-subtract decay that follows it.
- A pseudo-random walk with idle gaps carrying junk data checks the rounding, and shows that the state holds when no sample arrives.
- Full-scale alternation between the two extremes drives the result into the clamp.

Further runs cover the remaining corners:
- A long constant input at the largest shift confirms the decay to zero.
- A change of k, and a clear, each landing on the same cycle as a sample, confirm that filtering restarts from rest.

// File: rtl/hpf_pkg.sv
package hpf_pkg;
  parameter int KW = 4;

  typedef struct packed {
    logic          load;
    logic          flush;
    logic          bypass;
    logic [KW-1:0] kEff;
  } hpfStrobe_t;
endpackage

// File: rtl/hpf_ctrl.sv
module hpf_ctrl
  import hpf_pkg::*;
#(
  parameter int KMAX = 12
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          clearIn,
  input  logic [KW-1:0] shiftK,
  input  logic          inValid,
  output hpfStrobe_t    strobe,
  output logic          outValid
);
  localparam logic [KW-1:0] K_LIMIT = KW'(KMAX);

  logic [KW-1:0] kPrev;
  logic          kChanged;

  assign kChanged = (shiftK != kPrev);

  always_comb begin
    strobe.load   = inValid;
    strobe.flush  = clearIn || kChanged;
    strobe.bypass = (shiftK == '0);
    strobe.kEff   = (shiftK > K_LIMIT) ? K_LIMIT : shiftK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kPrev    <= '0;
      outValid <= 1'b0;
    end else begin
      kPrev    <= shiftK;
      outValid <= inValid;
    end
  end

  AST_K_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.bypass |-> (strobe.kEff >= 1 && strobe.kEff <= K_LIMIT)); // R3

  AST_K_HIGH_CODES: assert property (@(posedge clk) disable iff (!rstN)
    (shiftK > K_LIMIT) |-> (strobe.kEff == K_LIMIT)); // R3
endmodule

// File: rtl/hpf_datapath.sv
module hpf_datapath
  import hpf_pkg::*;
#(
  parameter int DW = 16,
  parameter int FW = 12,
  parameter int GB = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  hpfStrobe_t           strobe,
  input  logic signed [DW-1:0] inSample,
  output logic signed [DW-1:0] outSample
);
  localparam int AW = DW + FW + GB;
  localparam int RW = AW - FW;
  localparam logic signed [AW-1:0] HALF    = AW'(1) <<< (FW - 1);
  localparam logic signed [AW-1:0] ACC_LIM = AW'(1) <<< (DW + FW + 2);
  localparam logic signed [RW-1:0] MAXV = {{(RW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [RW-1:0] MINV = {{(RW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic signed [DW-1:0] xPrev;
  logic signed [AW-1:0] yAcc;

  logic signed [DW-1:0] xBase;
  logic signed [AW-1:0] yBase;
  logic signed [AW-1:0] xExt, pExt, diffScaled, leak, yNext, yRound;
  logic signed [RW-1:0] rounded;
  logic signed [DW-1:0] satOut;

  always_comb begin
    xBase      = strobe.flush ? '0 : xPrev;
    yBase      = strobe.flush ? '0 : yAcc;
    xExt       = {{(AW-DW){inSample[DW-1]}}, inSample};
    pExt       = {{(AW-DW){xBase[DW-1]}}, xBase};
    diffScaled = (xExt - pExt) <<< FW;
    leak       = yBase >>> strobe.kEff;
    yNext      = yBase - leak + diffScaled;
    yRound     = yNext + HALF;
    rounded    = yRound[AW-1:FW];
    if (rounded > MAXV)      satOut = MAXV[DW-1:0];
    else if (rounded < MINV) satOut = MINV[DW-1:0];
    else                     satOut = rounded[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xPrev     <= '0;
      yAcc      <= '0;
      outSample <= '0;
    end else if (strobe.load) begin
      if (strobe.bypass) begin
        xPrev     <= '0;
        yAcc      <= '0;
        outSample <= inSample;
      end else begin
        xPrev     <= inSample;
        yAcc      <= yNext;
        outSample <= satOut;
      end
    end else if (strobe.flush) begin
      xPrev <= '0;
      yAcc  <= '0;
    end
  end

  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.load && strobe.bypass) |=> (outSample == $past(inSample))); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.load && !strobe.flush) |=> ($stable(yAcc) && $stable(xPrev) && $stable(outSample))); // R5

  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> $stable(outSample)); // R5

  AST_FLUSH_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.flush && !strobe.load) |=> (yAcc == '0 && xPrev == '0)); // R6

  AST_ACC_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (yAcc < ACC_LIM) && (yAcc > -ACC_LIM)); // R8
endmodule

// File: rtl/hpf_dc_block.sv
module hpf_dc_block
  import hpf_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FW   = 12,
  parameter int GB   = 4,
  parameter int KMAX = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 clearIn,
  input  logic [KW-1:0]        shiftK,
  input  logic                 inValid,
  input  logic signed [DW-1:0] inSample,
  output logic                 outValid,
  output logic signed [DW-1:0] outSample
);
  hpfStrobe_t strobe;

  hpf_ctrl #(.KMAX(KMAX)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .clearIn  (clearIn),
    .shiftK   (shiftK),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  hpf_datapath #(.DW(DW), .FW(FW), .GB(GB)) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .inSample  (inSample),
    .outSample (outSample)
  );

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(inValid)); // R4

  AST_VALID_NO_GHOST: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid); // R4
endmodule

// File: tb/test_hpf_dc_block.sv
module test_hpf_dc_block;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearIn = 1'b0;
  logic [3:0] shiftK = 4'd0;
  logic inValid = 1'b0;
  logic signed [15:0] inSample = '0;
  logic outValid;
  logic signed [15:0] outSample;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  longint mAcc = 0;
  longint mXp = 0;
  int mK = 0;
  logic expValid = 1'b0;
  longint expOut = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  hpf_dc_block i_hpf_dc_block (
    .clk(clk), .rstN(rstN), .clearIn(clearIn), .shiftK(shiftK),
    .inValid(inValid), .inSample(inSample),
    .outValid(outValid), .outSample(outSample)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint modelStep(input longint x);
    int ke;
    longint r;
    ke = (shiftK > 12) ? 12 : int'(shiftK);
    if (shiftK == 0) begin
      mAcc = 0;
      mXp = 0;
      return x;
    end
    mAcc = mAcc - (mAcc >>> ke) + ((x - mXp) <<< 12);
    mXp = x;
    r = (mAcc + 2048) >>> 12;
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  // One clock: drive at negedge, advance model, check at next negedge.
  task automatic step(input string tag, input logic v, input longint x, input logic clr);
    inValid  = v;
    inSample = 16'(x);
    clearIn  = clr;
    if (clr || int'(shiftK) != mK) begin
      mAcc = 0;
      mXp = 0;
    end
    mK = int'(shiftK);
    if (v) expOut = modelStep(x);
    expValid = v;
    @(negedge clk);
    check({tag, " R4 valid"}, longint'(outValid), longint'(expValid));
    check(tag, longint'(outSample), expOut);
  endtask

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step({tag, " R5 idle"}, 1'b0, longint'($signed(lfsr)), 1'b0);
    end
  endtask

  initial begin
    longint firstOut;
    repeat (3) @(negedge clk);
    check("R11 reset valid", longint'(outValid), 0);
    check("R11 reset out", longint'(outSample), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R11 out after reset", longint'(outSample), 0);

    for (int k = 0; k < 16; k++) begin
      shiftK = 4'(k);
      step("R7 k change idle", 1'b0, 0, 1'b0);
      // step from rest
      inValid = 1'b1;
      step(k == 0 ? "R2 step" : (k > 12 ? "R3 step" : "R9 step"), 1'b1, 1000, 1'b0);
      check("R9 first equals step", longint'(outSample), 1000);
      for (int i = 0; i < 39; i++)
        step(k == 0 ? "R2 hold" : (k > 12 ? "R3 hold" : "R1 hold"), 1'b1, 1000, 1'b0);
      step("R6 clear idle", 1'b0, 0, 1'b1);
      // random walk with gaps
      for (int i = 0; i < 200; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(k == 0 ? "R2 rand" : (k > 12 ? "R3 rand" : "R1 rand"), 1'b1,
             longint'($signed(lfsr)) >>> 2, 1'b0);
        if (i % 37 == 5) idle("gap", 2);
      end
      // full-scale alternation
      for (int i = 0; i < 20; i++)
        step("R8 extreme", 1'b1, (i % 2 == 0) ? -32768 : 32767, 1'b0);
      // clear coincident with sample
      step("R6 clear with sample", 1'b1, -500, 1'b1);
      if (k != 0) check("R6 restart from zero", longint'(outSample), -500);
      step("R1 after clear", 1'b1, -400, 1'b0);
    end

    // k change coincident with a sample
    shiftK = 4'd3;
    step("R7 setup", 1'b1, 2000, 1'b0);
    step("R7 setup", 1'b1, 2000, 1'b0);
    shiftK = 4'd5;
    step("R7 change with sample", 1'b1, 700, 1'b0);
    check("R7 restart from zero", longint'(outSample), 700);

    // long decay at the largest shift
    shiftK = 4'd12;
    step("R7 k change", 1'b0, 0, 1'b0);
    for (int i = 0; i < 40000; i++) step("R10 decay", 1'b1, 1000, 1'b0);
    firstOut = longint'(outSample);
    check("R10 decayed", (firstOut <= 1 && firstOut >= -1) ? 1 : 0, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule